// File: doc/BRIEF.md
# Packet Header Match Filter

This block sits at the receive side of one switch port and inspects the start of every incoming packet. Packet data arrives as 32-bit words with start and end markers. The first five words form a 160-bit header window. Each of four programmable comparators holds a 160-bit value and a 160-bit don't-care mask. Every comparator decides on its own whether the header window matches. Each comparator has two enables of its own. With the filter enable set, a hit drops the packet. With the trace enable set, a hit copies the packet to the trace output. With both set, a hit does both.

The drop decision is registered and issued one cycle after the last header word, or after the end word of a shorter packet. The trace decision waits for the end of the packet, because only then is it known whether the packet had a physical error or was too long. Such packets are never copied to the trace output. A trace copy can also raise a port-write request. For each comparator, a saturating counter records the packets it filtered and another records the packets it traced.

The control is a three-state machine. `ST_IDLE` waits for a start word. `ST_HDR` collects the header words. `ST_BODY` waits for the end word. The transitions are:
- ST_IDLE to ST_HDR on a start word that is neither the last header word nor an end word.
- ST_IDLE or ST_HDR to ST_BODY on the last header word when it is not an end word.
- ST_HDR stays in ST_HDR on a further header word.
- Any state to ST_IDLE on an accepted end word.

Top module: `hdr_match_filter`

## Requirements
- R1: Header word k (k = 0..4, word 0 is the start word) is compared with `cfg_value[(i*5+k)*32 +: 32]` for comparator i. Bit 31 of a word is the earliest packet bit. A mask bit of 1 in `cfg_mask` at the same position is don't-care. A comparator matches when every bit it cares about is equal.
- R2: The four comparators are evaluated independently, and `dec_hit[i]` reports the match of comparator i.
- R3: `dec_valid` pulses for one cycle, in the cycle after the fifth word is accepted. In that cycle, `dec_drop` is 1 exactly when some comparator matched and has its bit set in `cfg_flt_en`.
- R4: When a packet ends before its fifth word, the decision is issued in the cycle after the end word. Header bits that were not received count as mismatches unless masked.
- R5: `trc_valid` pulses in the cycle after the end word. In that cycle, `trc_copy` is 1 when some comparator matched and has its bit set in `cfg_trc_en`, whether or not the packet is dropped.
- R6: A packet with `in_err` on any of its words, or with more than `MAX_WORDS` words (69 by default), never gets `trc_copy`. Its drop decision is unaffected.
- R7: `trc_pw_req` equals `trc_copy` gated by `cfg_pw_en`.
- R8: `dec_local` is 1 when the start word carried `in_hop0` and the packet is not dropped.
- R9: Each comparator has a filter counter in `flt_cnt` that rises by one for every packet it drops and holds at all ones.
- R10: Each comparator has a trace counter in `trc_cnt` that rises by one for every traced packet it matched with its trace enable set, and holds at all ones.
- R11: Words with `in_valid` low are ignored. Words in idle without `in_sop` are also ignored.
- R12: After reset, all decision outputs and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Data word valid |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | WORD_W | Packet data word, bit 31 earliest |
| in_err | input | 1 | Physical error seen on this word |
| in_hop0 | input | 1 | Maintenance packet with hop count 0, sampled on the start word |
| cfg_value | input | NCMP*HDR_WORDS*WORD_W | Comparison values |
| cfg_mask | input | NCMP*HDR_WORDS*WORD_W | Don't-care masks, 1 = ignore |
| cfg_flt_en | input | NCMP | Filter enable per comparator |
| cfg_trc_en | input | NCMP | Trace enable per comparator |
| cfg_pw_en | input | 1 | Port-write request enable |
| dec_valid | output | 1 | Header decision strobe |
| dec_drop | output | 1 | Packet is dropped |
| dec_hit | output | NCMP | Per-comparator match |
| dec_local | output | 1 | Hop-zero packet may be processed locally |
| trc_valid | output | 1 | End-of-packet trace strobe |
| trc_copy | output | 1 | Copy packet to the trace output |
| trc_pw_req | output | 1 | Port-write request |
| flt_cnt | output | NCMP*CNT_W | Filter match counters |
| trc_cnt | output | NCMP*CNT_W | Trace match counters |

## Verification
Some properties are checked on every cycle:
- Every decision and trace strobe follows an accepted word or an end word.
- A trace copy never follows a word flagged as errored.
- A port-write request occurs only with a copy.
- Each counter either holds its value or rises by exactly one.

Other behaviour only the directed scenarios can show: the bit alignment of the comparison, the don't-care handling, the extra masking for short packets, the suppression for over-length packets, the hop-zero qualification and saturation at all ones. The bench checks these against a model computed from the configuration.

// File: rtl/hf_pkg.sv
package hf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_BODY = 2'd2
    } hf_state_e;
endpackage

// File: rtl/hf_cmp.sv
module hf_cmp #(
    parameter int WORD_W    = 32,
    parameter int HDR_WORDS = 5,
    localparam int IW       = $clog2(HDR_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        word_en,
    input  logic                        first,
    input  logic [IW-1:0]               idx,
    input  logic [WORD_W-1:0]           data,
    input  logic [HDR_WORDS*WORD_W-1:0] val,
    input  logic [HDR_WORDS*WORD_W-1:0] msk,
    output logic                        hit_now
);
    logic                 ok_r;
    logic                 word_ok;
    logic [HDR_WORDS-1:0] tail_ok;
    logic [WORD_W-1:0]    val_w;
    logic [WORD_W-1:0]    msk_w;

    // tail_ok[k]: every word after k is fully don't-care
    assign tail_ok[HDR_WORDS-1] = 1'b1;
    for (genvar k = 0; k < HDR_WORDS-1; k++) begin : g_tail
        assign tail_ok[k] = tail_ok[k+1] & (&msk[(k+1)*WORD_W +: WORD_W]);
    end

    always_comb begin
        val_w   = val[idx*WORD_W +: WORD_W];
        msk_w   = msk[idx*WORD_W +: WORD_W];
        word_ok = &(~(data ^ val_w) | msk_w);
        hit_now = (first | ok_r) & word_ok & tail_ok[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_r <= 1'b0;
        end else if (word_en) begin
            ok_r <= (first | ok_r) & word_ok;
        end
    end
endmodule

// File: rtl/hf_satcnt.sv
module hf_satcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && (cnt != {CNT_W{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hdr_match_filter.sv
module hdr_match_filter
    import hf_pkg::*;
#(
    parameter int NCMP      = 4,
    parameter int WORD_W    = 32,
    parameter int HDR_WORDS = 5,
    parameter int MAX_WORDS = 69,
    parameter int CNT_W     = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic                             in_sop,
    input  logic                             in_eop,
    input  logic [WORD_W-1:0]                in_data,
    input  logic                             in_err,
    input  logic                             in_hop0,
    input  logic [NCMP*HDR_WORDS*WORD_W-1:0] cfg_value,
    input  logic [NCMP*HDR_WORDS*WORD_W-1:0] cfg_mask,
    input  logic [NCMP-1:0]                  cfg_flt_en,
    input  logic [NCMP-1:0]                  cfg_trc_en,
    input  logic                             cfg_pw_en,
    output logic                             dec_valid,
    output logic                             dec_drop,
    output logic [NCMP-1:0]                  dec_hit,
    output logic                             dec_local,
    output logic                             trc_valid,
    output logic                             trc_copy,
    output logic                             trc_pw_req,
    output logic [NCMP*CNT_W-1:0]            flt_cnt,
    output logic [NCMP*CNT_W-1:0]            trc_cnt
);
    localparam int IW    = $clog2(HDR_WORDS);
    localparam int LEN_W = $clog2(MAX_WORDS + 1);
    localparam int HB    = HDR_WORDS * WORD_W;

    hf_state_e   state, nxt;
    logic [IW-1:0]    hidx_r, idx_cur;
    logic [LEN_W-1:0] wcnt_r;
    logic             err_r, hop_r;
    logic [NCMP-1:0]  hit_r, hit_now, hits_final;
    logic [NCMP-1:0]  flt_inc, trc_inc;
    logic             accept, first, hdr_word, hdr_last, pkt_end;
    logic             too_long, err_now, hop_cur, drop_now;

    always_comb begin
        first    = (state == ST_IDLE);
        accept   = in_valid & (~first | in_sop);
        idx_cur  = first ? '0 : hidx_r;
        hdr_word = accept & (first | (state == ST_HDR));
        hdr_last = hdr_word & (in_eop | (idx_cur == IW'(HDR_WORDS-1)));
        pkt_end  = accept & in_eop;
        too_long = ~first & (wcnt_r >= LEN_W'(MAX_WORDS));
        err_now  = (~first & err_r) | in_err | too_long;
        hop_cur  = first ? in_hop0 : hop_r;
        drop_now = |(hit_now & cfg_flt_en);
        hits_final = hdr_word ? hit_now : hit_r;
        flt_inc  = {NCMP{hdr_last}} & hit_now & cfg_flt_en;
        trc_inc  = {NCMP{pkt_end & ~err_now}} & hits_final & cfg_trc_en;
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        hf_cmp #(.WORD_W(WORD_W), .HDR_WORDS(HDR_WORDS)) u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .word_en(hdr_word),
            .first  (first),
            .idx    (idx_cur),
            .data   (in_data),
            .val    (cfg_value[i*HB +: HB]),
            .msk    (cfg_mask[i*HB +: HB]),
            .hit_now(hit_now[i])
        );
        hf_satcnt #(.CNT_W(CNT_W)) u_fcnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (flt_inc[i]),
            .cnt  (flt_cnt[i*CNT_W +: CNT_W])
        );
        hf_satcnt #(.CNT_W(CNT_W)) u_tcnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (trc_inc[i]),
            .cnt  (trc_cnt[i*CNT_W +: CNT_W])
        );
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_HDR: begin
                if (accept) begin
                    if (in_eop)        nxt = ST_IDLE;
                    else if (hdr_last) nxt = ST_BODY;
                    else               nxt = ST_HDR;
                end
            end
            ST_BODY: begin
                if (pkt_end) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // per-packet context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hidx_r <= '0;
            wcnt_r <= '0;
            err_r  <= 1'b0;
            hop_r  <= 1'b0;
            hit_r  <= '0;
        end else if (accept) begin
            if (hdr_word && !hdr_last) hidx_r <= idx_cur + 1'b1;
            if (first)                          wcnt_r <= LEN_W'(1);
            else if (wcnt_r < LEN_W'(MAX_WORDS)) wcnt_r <= wcnt_r + 1'b1;
            err_r <= err_now;
            hop_r <= hop_cur;
            if (hdr_last) hit_r <= hit_now;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_drop   <= 1'b0;
            dec_hit    <= '0;
            dec_local  <= 1'b0;
            trc_valid  <= 1'b0;
            trc_copy   <= 1'b0;
            trc_pw_req <= 1'b0;
        end else begin
            dec_valid  <= hdr_last;
            dec_drop   <= hdr_last & drop_now;
            dec_local  <= hdr_last & hop_cur & ~drop_now;
            if (hdr_last) dec_hit <= hit_now;
            trc_valid  <= pkt_end;
            trc_copy   <= |trc_inc;
            trc_pw_req <= (|trc_inc) & cfg_pw_en;
        end
    end
endmodule

// File: rtl/hdr_match_filter_chk.sv
module hdr_match_filter_chk #(
    parameter int NCMP  = 4,
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_eop,
    input logic                  in_err,
    input logic                  dec_valid,
    input logic                  trc_valid,
    input logic                  trc_copy,
    input logic                  trc_pw_req,
    input logic [NCMP*CNT_W-1:0] flt_cnt,
    input logic [NCMP*CNT_W-1:0] trc_cnt
);
    // R3: a decision only follows an accepted data word
    p_dec_after_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid));

    // R5: the trace strobe only follows an end word
    p_trc_after_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trc_valid |-> $past(in_valid && in_eop));

    // R5: a copy is only signalled together with its strobe
    p_copy_in_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trc_copy |-> trc_valid);

    // R6: an errored end word never yields a copy
    p_err_no_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trc_copy |-> !$past(in_err));

    // R7: port-write only with a copy
    p_pw_with_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trc_pw_req |-> trc_copy);

    for (genvar g = 0; g < NCMP; g++) begin : g_cnt
        // R9: filter counter holds or steps by one
        p_flt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_cnt[g*CNT_W +: CNT_W] == $past(flt_cnt[g*CNT_W +: CNT_W])) ||
            (flt_cnt[g*CNT_W +: CNT_W] == $past(flt_cnt[g*CNT_W +: CNT_W]) + 1'b1));
        // R10: trace counter holds or steps by one
        p_trc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (trc_cnt[g*CNT_W +: CNT_W] == $past(trc_cnt[g*CNT_W +: CNT_W])) ||
            (trc_cnt[g*CNT_W +: CNT_W] == $past(trc_cnt[g*CNT_W +: CNT_W]) + 1'b1));
    end
endmodule

bind hdr_match_filter hdr_match_filter_chk #(.NCMP(NCMP), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/hdr_match_filter_bench.sv
module hdr_match_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int WW = 32;
    localparam int HW = 5;
    localparam int MAXW = 69;
    localparam int CW = 4;
    localparam int SATV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0, in_hop0 = 1'b0;
    logic [WW-1:0] in_data = '0;
    logic [NC*HW*WW-1:0] cfg_value, cfg_mask;
    logic [NC-1:0] cfg_flt_en = '0, cfg_trc_en = '0;
    logic cfg_pw_en = 1'b0;
    logic dec_valid, dec_drop, dec_local, trc_valid, trc_copy, trc_pw_req;
    logic [NC-1:0] dec_hit;
    logic [NC*CW-1:0] flt_cnt, trc_cnt;

    logic [31:0] bv [NC][HW];
    logic [31:0] bm [NC][HW];
    logic [31:0] pkt [0:79];
    int mf [NC];
    int mt [NC];
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++)
            for (int k = 0; k < HW; k++) begin
                cfg_value[(i*HW+k)*WW +: WW] = bv[i][k];
                cfg_mask[(i*HW+k)*WW +: WW]  = bm[i][k];
            end
    end

    hdr_match_filter #(.NCMP(NC), .WORD_W(WW), .HDR_WORDS(HW), .MAX_WORDS(MAXW), .CNT_W(CW))
    u_hdr_match_filter (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0; in_hop0 = 1'b0;
        end
    endtask

    task automatic push(input logic [31:0] d, input bit s, input bit e, input bit er,
                        input bit hp, input bit v);
        @(negedge clk);
        in_valid = v; in_sop = s; in_eop = e; in_err = er; in_hop0 = hp; in_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic fill_pkt(input int seed);
        for (int w = 0; w < 80; w++) pkt[w] = 32'h5A00_0000 ^ (seed * 32'h0101_0037) ^ (w * 32'h0001_1001);
    endtask

    task automatic reset_cfg();
        for (int i = 0; i < NC; i++)
            for (int k = 0; k < HW; k++) begin
                bv[i][k] = 32'hDEAD_0000 + i*16 + k;
                bm[i][k] = '0;
            end
        cfg_flt_en = '0; cfg_trc_en = '0; cfg_pw_en = 1'b0;
    endtask

    task automatic copy_to(input int i);
        for (int k = 0; k < HW; k++) bv[i][k] = pkt[k];
    endtask

    function automatic logic [NC-1:0] model_hit(input int n);
        logic [NC-1:0] h;
        for (int i = 0; i < NC; i++) begin
            h[i] = 1'b1;
            for (int k = 0; k < HW; k++) begin
                if (k < n) begin
                    if (((pkt[k] ^ bv[i][k]) & ~bm[i][k]) != 0) h[i] = 1'b0;
                end else if (bm[i][k] != 32'hFFFF_FFFF) h[i] = 1'b0;
            end
        end
        return h;
    endfunction

    // sends one packet of n words and checks every decision against the model
    task automatic send_pkt(input int n, input int err_at, input bit hop0, input bit gaps);
        int dec_at;
        logic [NC-1:0] eh;
        bit err, edrop, ecopy;
        dec_at = (n < HW) ? n - 1 : HW - 1;
        eh = model_hit(n);
        err = (err_at >= 0) || (n > MAXW);
        edrop = |(eh & cfg_flt_en);
        ecopy = (|(eh & cfg_trc_en)) && !err;
        for (int w = 0; w < n; w++) begin
            if (gaps) push(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            push(pkt[w], w == 0, w == n-1, w == err_at, hop0 && (w == 0), 1'b1);
            if ((w == dec_at) || (w < 6) || (w == n-1)) begin
                chk((n < HW) ? "R4 decision timing" : "R3 decision timing", dec_valid, w == dec_at);
                chk("R5 trace strobe timing", trc_valid, w == n-1);
            end
            if (w == dec_at) begin
                chk("R1 R2 per-comparator hit", dec_hit, eh);
                chk("R3 drop", dec_drop, edrop);
                chk("R8 local accept", dec_local, hop0 && !edrop);
                for (int i = 0; i < NC; i++)
                    if (eh[i] && cfg_flt_en[i] && mf[i] < SATV) mf[i]++;
            end
            if (w == n-1) begin
                chk(err ? "R6 no trace on error" : "R5 trace copy", trc_copy, ecopy);
                chk("R7 port-write", trc_pw_req, ecopy && cfg_pw_en);
                for (int i = 0; i < NC; i++)
                    if (eh[i] && cfg_trc_en[i] && !err && mt[i] < SATV) mt[i]++;
            end
        end
        idle(1);
        for (int i = 0; i < NC; i++) begin
            chk("R9 filter counter", flt_cnt[i*CW +: CW], mf[i]);
            chk("R10 trace counter", trc_cnt[i*CW +: CW], mt[i]);
        end
    endtask

    task automatic t_reset();
        chk("R12 dec_valid", dec_valid, 0);
        chk("R12 dec_drop", dec_drop, 0);
        chk("R12 trc_valid", trc_valid, 0);
        chk("R12 trc_copy", trc_copy, 0);
        chk("R12 flt_cnt", flt_cnt, 0);
        chk("R12 trc_cnt", trc_cnt, 0);
    endtask

    task automatic t_exact();
        reset_cfg(); fill_pkt(1); copy_to(0); cfg_flt_en = 4'b0001;
        send_pkt(8, -1, 1'b0, 1'b0);
        chk("R3 drop expected", dec_drop, 0); // strobe over; value cleared
    endtask

    task automatic t_mask();
        reset_cfg(); fill_pkt(2);
        copy_to(1); bv[1][2] ^= 32'h0000_0080; bm[1][2] = 32'h0000_0080;
        copy_to(2); bv[2][4] ^= 32'h0000_0001;
        copy_to(3); bv[3][0] ^= 32'h8000_0000;
        cfg_flt_en = 4'b0110;
        send_pkt(6, -1, 1'b0, 1'b0);
        chk("R1 masked word hits", model_hit(6), 4'b0010);
    endtask

    task automatic t_both();
        reset_cfg(); fill_pkt(3); copy_to(0); copy_to(2);
        cfg_flt_en = 4'b0001; cfg_trc_en = 4'b0001; cfg_pw_en = 1'b1;
        send_pkt(10, -1, 1'b0, 1'b0);
    endtask

    task automatic t_trace_only();
        reset_cfg(); fill_pkt(4); copy_to(1); cfg_trc_en = 4'b0010;
        send_pkt(7, -1, 1'b0, 1'b0);
        cfg_pw_en = 1'b1;
        send_pkt(5, -1, 1'b0, 1'b0);
    endtask

    task automatic t_short();
        reset_cfg(); fill_pkt(5);
        copy_to(0); bm[0][3] = '1; bm[0][4] = '1;
        copy_to(1);
        for (int k = 0; k < HW; k++) bm[3][k] = '1;
        cfg_flt_en = 4'b1011; cfg_trc_en = 4'b0001;
        send_pkt(3, -1, 1'b0, 1'b0);
        send_pkt(1, -1, 1'b0, 1'b0);
    endtask

    task automatic t_err();
        reset_cfg(); fill_pkt(6); copy_to(0);
        cfg_flt_en = 4'b0001; cfg_trc_en = 4'b0001; cfg_pw_en = 1'b1;
        send_pkt(8, 6, 1'b0, 1'b0);
        send_pkt(MAXW + 1, -1, 1'b0, 1'b0);
        send_pkt(MAXW, -1, 1'b0, 1'b0);
    endtask

    task automatic t_hop0();
        reset_cfg(); fill_pkt(7); copy_to(2); cfg_flt_en = 4'b0100;
        send_pkt(6, -1, 1'b1, 1'b0);
        cfg_flt_en = 4'b0000;
        send_pkt(6, -1, 1'b1, 1'b0);
    endtask

    task automatic t_ignore();
        reset_cfg(); fill_pkt(8); copy_to(0); cfg_flt_en = 4'b0001; cfg_trc_en = 4'b0001;
        for (int c = 0; c < 3; c++) begin
            push(pkt[c], 1'b0, c == 2, 1'b0, 1'b0, 1'b1);
            chk("R11 idle word ignored", dec_valid, 0);
            chk("R11 idle eop ignored", trc_valid, 0);
        end
        idle(1);
        send_pkt(7, -1, 1'b0, 1'b1);
    endtask

    task automatic t_sat();
        reset_cfg(); fill_pkt(9); copy_to(3);
        cfg_flt_en = 4'b1000; cfg_trc_en = 4'b1000;
        for (int p = 0; p < SATV + 3; p++) send_pkt(5, -1, 1'b0, 1'b0);
        chk("R9 filter saturates", flt_cnt[3*CW +: CW], SATV);
        chk("R10 trace saturates", trc_cnt[3*CW +: CW], SATV);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) begin mf[i] = 0; mt[i] = 0; end
        reset_cfg();
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 t_reset();
        t_exact();
        t_mask();
        t_both();
        t_trace_only();
        t_short();
        t_err();
        t_hop0();
        t_ignore();
        t_sat();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule